// File: doc/BRIEF.md
# Immediate-Operand Execute Unit

This unit runs the immediate-operand instructions of a small 8-bit accumulator processor. It takes one 16-bit instruction word per cycle, qualified by a valid strobe. It holds the architectural state those instructions touch:

- the working register W;
- five status flags;
- a 4-bit bank-select register;
- a 16-bit product register pair;
- three 12-bit pointer registers.

Each accepted word updates that state at the next clock edge.

Return-with-literal is reported to the surrounding core as a one-cycle event. The unit then takes a second cycle in which it ignores its input. The pointer load is a two-word instruction. The first word selects the pointer and carries the upper literal bits. The following accepted word supplies the lower byte and completes the load.

Program counter handling, the return stack and memory access belong to the enclosing core. An undefined word raises a one-cycle illegal-opcode indication and changes nothing.

Top module: `lit_exec_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, W, status, bank, product and all pointers read zero. `ready_o` is 1, and `ret_o` and `illegal_o` are 0.
- R2: An accepted word 0x0Fkk (add) sets W = W + kk. `status_o` bits are {N,OV,Z,DC,C} in positions 4..0. The flags are set as follows:
  - C is the carry out of bit 7.
  - DC is the carry out of bit 3.
  - OV is signed two's-complement overflow.
  - N is result bit 7.
  - Z is set when the result is 0.
- R3: An accepted word 0x08kk (subtract) sets W = kk - W. C is 1 when kk >= W (no borrow). DC is 1 when kk[3:0] >= W[3:0]. OV is signed overflow of kk - W. Z and N follow the result.
- R4: Accepted words 0x0Bkk (AND), 0x09kk (inclusive OR) and 0x0Akk (exclusive OR) write W op kk to W and update Z and N. C, DC and OV are unchanged.
- R5: An accepted word 0x0Ekk loads kk into W and leaves the status flags unchanged.
- R6: An accepted word 0x0Dkk writes the unsigned product W*kk to `prod_o` (high byte in bits 15:8). W and the flags are unchanged.
- R7: An accepted word 0x0Ckk loads kk into W without changing the flags. In the next cycle `ret_o` is 1 and `ready_o` is 0. A word presented during that cycle is ignored and changes no state.
- R8: An accepted word 0x010k (bits 7:4 zero) writes k into the bank register and changes no flags.
- R9: A word 0xEE0h, 0xEE1h or 0xEE2h opens a pointer load, and the next accepted word completes it. The field in bits 5:4 selects pointer 0..2 and bits 3:0 give literal bits 11:8. If that next word has top nibble 0xF, its low byte completes pointer {h, low byte}. Pointer i appears at `ptr_o` bits 12i+11..12i. If the next accepted word has any other top nibble, the load is dropped and that word executes normally. A word 0xEE3h is illegal.
- R10: A word with top nibble 0xF that does not follow an open pointer load changes no state and does not raise `illegal_o`.
- R11: Any other encoding raises `illegal_o` in the next cycle and leaves W, flags, bank, product and pointers unchanged. It also drops an open pointer load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| wreg_o | output | 8 | Working register |
| status_o | output | 5 | Flags {N,OV,Z,DC,C} |
| bank_o | output | 4 | Bank-select register |
| prod_o | output | 16 | Product register pair |
| ptr_o | output | 36 | Three 12-bit pointer registers, pointer 0 in the low bits |
| ret_o | output | 1 | Return-with-literal event |
| illegal_o | output | 1 | Undefined encoding seen |
| ready_o | output | 1 | Low during the second cycle of a return |

## Verification
The bound assertions watch several properties on every cycle:
- An illegal word and a word presented while not ready leave all state untouched.
- The logical operations never alter carry, digit carry or overflow.
- Move and bank loads copy their literal exactly.
- The product equals the previous W times the literal.

The flag arithmetic at its edges can be shown only by the bench's scenarios: signed overflow, the wrap through zero, and subtract borrows on the full byte and on the low nibble. The same holds for the pairing of pointer words: completion, cancellation by an intervening word, and a lone second word.

// File: rtl/lit_exec_pkg.sv
package lit_exec_pkg;

    localparam int INSTR_W = 16;
    localparam int SEL_W   = 2;
    localparam int FLAG_W  = 5;
    localparam int NIB_W   = 4;

    localparam int FLG_C  = 0;
    localparam int FLG_DC = 1;
    localparam int FLG_Z  = 2;
    localparam int FLG_OV = 3;
    localparam int FLG_N  = 4;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_AND,
        OP_IOR,
        OP_XOR,
        OP_MOV,
        OP_MUL,
        OP_RET,
        OP_SUB,
        OP_BANK,
        OP_PTR1,
        OP_PTR2,
        OP_SKIP,
        OP_ILL
    } op_e;

endpackage

// File: rtl/lit_decode.sv
module lit_decode
    import lit_exec_pkg::*;
#(
    parameter int NUM_PTR = 3
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               pend,
    output op_e                op
);

    logic [3:0] top_nib;
    logic [3:0] sub_nib;
    logic [3:0] mid_nib;
    logic [1:0] guard;
    logic [SEL_W-1:0] sel_fld;
    logic sel_ok;

    assign top_nib = instr[15:12];
    assign sub_nib = instr[11:8];
    assign mid_nib = instr[7:4];
    assign guard   = instr[7:6];
    assign sel_fld = instr[5:4];
    assign sel_ok  = (32'(sel_fld) < NUM_PTR);

    always_comb begin
        op = OP_ILL;
        case (top_nib)
            4'h0: begin
                if (sub_nib == 4'h1) begin
                    op = (mid_nib == 4'h0) ? OP_BANK : OP_ILL;
                end else begin
                    case (sub_nib)
                        4'hF:    op = OP_ADD;
                        4'hB:    op = OP_AND;
                        4'h9:    op = OP_IOR;
                        4'hA:    op = OP_XOR;
                        4'hE:    op = OP_MOV;
                        4'hD:    op = OP_MUL;
                        4'hC:    op = OP_RET;
                        4'h8:    op = OP_SUB;
                        default: op = OP_ILL;
                    endcase
                end
            end
            4'hE: begin
                if (sub_nib == 4'hE && guard == 2'b00 && sel_ok) begin
                    op = OP_PTR1;
                end
            end
            4'hF: op = pend ? OP_PTR2 : OP_SKIP;
            default: op = OP_ILL;
        endcase
    end

endmodule

// File: rtl/lit_alu.sv
module lit_alu
    import lit_exec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_e                 op,
    input  logic [DATA_W-1:0]   w_in,
    input  logic [DATA_W-1:0]   lit,
    input  logic [FLAG_W-1:0]   flags_in,
    output logic [DATA_W-1:0]   res,
    output logic [FLAG_W-1:0]   flags_out,
    output logic [2*DATA_W-1:0] prod
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] add_full;
    logic [NIB_W:0]  add_half;
    logic [DATA_W:0] sub_full;
    logic [NIB_W:0]  sub_half;
    logic [DATA_W-1:0] w_inv;

    assign w_inv    = ~w_in;
    assign add_full = {1'b0, w_in} + {1'b0, lit};
    assign add_half = {1'b0, w_in[NIB_W-1:0]} + {1'b0, lit[NIB_W-1:0]};
    assign sub_full = {1'b0, lit} + {1'b0, w_inv} + {{DATA_W{1'b0}}, 1'b1};
    assign sub_half = {1'b0, lit[NIB_W-1:0]} + {1'b0, w_inv[NIB_W-1:0]}
                    + {{NIB_W{1'b0}}, 1'b1};
    assign prod     = {{DATA_W{1'b0}}, w_in} * {{DATA_W{1'b0}}, lit};

    always_comb begin
        res       = w_in;
        flags_out = flags_in;
        case (op)
            OP_ADD: begin
                res               = add_full[DATA_W-1:0];
                flags_out[FLG_C]  = add_full[DATA_W];
                flags_out[FLG_DC] = add_half[NIB_W];
                flags_out[FLG_OV] = (w_in[MSB] == lit[MSB]) && (res[MSB] != w_in[MSB]);
            end
            OP_SUB: begin
                res               = sub_full[DATA_W-1:0];
                flags_out[FLG_C]  = sub_full[DATA_W];
                flags_out[FLG_DC] = sub_half[NIB_W];
                flags_out[FLG_OV] = (lit[MSB] != w_in[MSB]) && (res[MSB] != lit[MSB]);
            end
            OP_AND:  res = w_in & lit;
            OP_IOR:  res = w_in | lit;
            OP_XOR:  res = w_in ^ lit;
            default: res = w_in;
        endcase
        if (op == OP_ADD || op == OP_SUB || op == OP_AND || op == OP_IOR || op == OP_XOR) begin
            flags_out[FLG_Z] = (res == '0);
            flags_out[FLG_N] = res[MSB];
        end
    end

endmodule

// File: rtl/lit_exec_unit.sv
module lit_exec_unit
    import lit_exec_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BANK_W  = 4,
    parameter int PTR_W   = 12,
    parameter int NUM_PTR = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     instr_valid,
    input  logic [INSTR_W-1:0]       instr,
    output logic [DATA_W-1:0]        wreg_o,
    output logic [FLAG_W-1:0]        status_o,
    output logic [BANK_W-1:0]        bank_o,
    output logic [2*DATA_W-1:0]      prod_o,
    output logic [NUM_PTR*PTR_W-1:0] ptr_o,
    output logic                     ret_o,
    output logic                     illegal_o,
    output logic                     ready_o
);

    localparam int HI_W = PTR_W - DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0]              w;
        logic [FLAG_W-1:0]              st;
        logic [BANK_W-1:0]              bank;
        logic [2*DATA_W-1:0]            prod;
        logic [NUM_PTR-1:0][PTR_W-1:0]  ptr;
        logic                           pend;
        logic [SEL_W-1:0]               psel;
        logic [HI_W-1:0]                phi;
        logic                           ret;
        logic                           ill;
        logic                           flush;
    } state_t;

    state_t q, d;

    op_e                 op;
    logic                accept;
    logic [DATA_W-1:0]   lit;
    logic [DATA_W-1:0]   alu_res;
    logic [FLAG_W-1:0]   alu_flags;
    logic [2*DATA_W-1:0] alu_prod;

    assign lit    = instr[DATA_W-1:0];
    assign accept = instr_valid && !q.flush;

    lit_decode #(.NUM_PTR(NUM_PTR)) u_dec (
        .instr (instr),
        .pend  (q.pend),
        .op    (op)
    );

    lit_alu #(.DATA_W(DATA_W)) u_alu (
        .op        (op),
        .w_in      (q.w),
        .lit       (lit),
        .flags_in  (q.st),
        .res       (alu_res),
        .flags_out (alu_flags),
        .prod      (alu_prod)
    );

    always_comb begin
        d       = q;
        d.ret   = 1'b0;
        d.ill   = 1'b0;
        d.flush = 1'b0;
        if (accept) begin
            d.pend = 1'b0;
            case (op)
                OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR: begin
                    d.w  = alu_res;
                    d.st = alu_flags;
                end
                OP_MOV: d.w = lit;
                OP_MUL: d.prod = alu_prod;
                OP_RET: begin
                    d.w     = lit;
                    d.ret   = 1'b1;
                    d.flush = 1'b1;
                end
                OP_BANK: d.bank = instr[BANK_W-1:0];
                OP_PTR1: begin
                    d.pend = 1'b1;
                    d.psel = instr[5:4];
                    d.phi  = instr[HI_W-1:0];
                end
                OP_PTR2: begin
                    for (int i = 0; i < NUM_PTR; i++) begin
                        if (32'(q.psel) == i) begin
                            d.ptr[i] = {q.phi, lit};
                        end
                    end
                end
                OP_SKIP: d.pend = 1'b0;
                default: d.ill = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wreg_o    = q.w;
    assign status_o  = q.st;
    assign bank_o    = q.bank;
    assign prod_o    = q.prod;
    assign ptr_o     = q.ptr;
    assign ret_o     = q.ret;
    assign illegal_o = q.ill;
    assign ready_o   = !q.flush;

endmodule

// File: rtl/lit_exec_checks.sv
module lit_exec_checks
    import lit_exec_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BANK_W  = 4,
    parameter int PTR_W   = 12,
    parameter int NUM_PTR = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     instr_valid,
    input logic [INSTR_W-1:0]       instr,
    input logic [DATA_W-1:0]        wreg_o,
    input logic [FLAG_W-1:0]        status_o,
    input logic [BANK_W-1:0]        bank_o,
    input logic [2*DATA_W-1:0]      prod_o,
    input logic [NUM_PTR*PTR_W-1:0] ptr_o,
    input logic                     ret_o,
    input logic                     illegal_o,
    input logic                     ready_o
);

    logic take;
    logic [7:0] hib;
    assign take = instr_valid && ready_o;
    assign hib  = instr[15:8];

    // R11: an illegal word leaves the whole state as it was
    a_r11_illegal_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ($stable(wreg_o) && $stable(status_o) && $stable(bank_o)
                       && $stable(prod_o) && $stable(ptr_o)));

    // R7: a word presented during the return's second cycle is ignored
    a_r7_flush_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o) |=> ($stable(wreg_o) && $stable(status_o) && $stable(bank_o)
                        && $stable(prod_o) && $stable(ptr_o) && !illegal_o && !ret_o));

    // R4: logical operations keep C, DC and OV
    a_r4_logic_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (hib == 8'h0B || hib == 8'h09 || hib == 8'h0A))
        |=> ($stable(status_o[FLG_C]) && $stable(status_o[FLG_DC]) && $stable(status_o[FLG_OV])));

    // R5: move copies the literal and keeps the flags
    a_r5_move_literal: assert property (@(posedge clk) disable iff (!rst_n)
        (take && hib == 8'h0E) |=> (wreg_o == $past(instr[DATA_W-1:0]) && $stable(status_o)));

    // R6: product of previous W and literal, W kept
    a_r6_product: assert property (@(posedge clk) disable iff (!rst_n)
        (take && hib == 8'h0D)
        |=> (prod_o == ({{DATA_W{1'b0}}, $past(wreg_o)} * {{DATA_W{1'b0}}, $past(instr[DATA_W-1:0])})
             && $stable(wreg_o) && $stable(status_o)));

    // R8: bank load takes the low nibble
    a_r8_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        (take && hib == 8'h01 && instr[7:4] == 4'h0)
        |=> (bank_o == $past(instr[BANK_W-1:0]) && $stable(status_o)));

    // R7 / R11: the two event pulses never coincide
    a_r7_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ret_o, illegal_o}));

endmodule

bind lit_exec_unit lit_exec_checks #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .PTR_W(PTR_W), .NUM_PTR(NUM_PTR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .wreg_o(wreg_o), .status_o(status_o), .bank_o(bank_o), .prod_o(prod_o),
    .ptr_o(ptr_o), .ret_o(ret_o), .illegal_o(illegal_o), .ready_o(ready_o)
);

// File: tb/lit_exec_unit_test.sv
module lit_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [7:0]  wreg_o;
    logic [4:0]  status_o;
    logic [3:0]  bank_o;
    logic [15:0] prod_o;
    logic [35:0] ptr_o;
    logic        ret_o, illegal_o, ready_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    lit_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .wreg_o(wreg_o), .status_o(status_o), .bank_o(bank_o), .prod_o(prod_o),
        .ptr_o(ptr_o), .ret_o(ret_o), .illegal_o(illegal_o), .ready_o(ready_o)
    );

    // reference model
    int    m_w, m_bank, m_prod, m_sel, m_phi;
    int    m_ptr [3];
    bit    m_c, m_dc, m_z, m_ov, m_n, m_pend, m_ret, m_ill, m_flush;
    string m_tag = "R1";

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    task automatic model_reset();
        m_w = 0; m_bank = 0; m_prod = 0; m_sel = 0; m_phi = 0;
        foreach (m_ptr[i]) m_ptr[i] = 0;
        {m_c, m_dc, m_z, m_ov, m_n, m_pend, m_ret, m_ill, m_flush} = '0;
    endtask

    task automatic model_step(input bit v, input logic [15:0] wd);
        int hi, k, r, s;
        bit was_pend, old_flush;
        old_flush = m_flush;
        m_ret = 0; m_ill = 0; m_flush = 0;
        if (v && !old_flush) begin
            hi = int'(wd[15:8]); k = int'(wd[7:0]);
            was_pend = m_pend; m_pend = 0;
            if (wd[15:12] == 4'hF) begin
                if (was_pend) m_ptr[m_sel] = m_phi * 256 + k;
            end else if (hi == 8'h0F) begin
                s = m_w + k; r = s % 256;
                m_c = (s > 255); m_dc = ((m_w % 16) + (k % 16)) > 15;
                s = sgn(m_w) + sgn(k); m_ov = (s > 127) || (s < -128);
                m_w = r; m_z = (r == 0); m_n = (r >= 128);
            end else if (hi == 8'h08) begin
                r = (k - m_w + 256) % 256;
                m_c = (k >= m_w); m_dc = ((k % 16) >= (m_w % 16));
                s = sgn(k) - sgn(m_w); m_ov = (s > 127) || (s < -128);
                m_w = r; m_z = (r == 0); m_n = (r >= 128);
            end else if (hi == 8'h0B || hi == 8'h09 || hi == 8'h0A) begin
                if (hi == 8'h0B) m_w = m_w & k;
                else if (hi == 8'h09) m_w = m_w | k;
                else m_w = m_w ^ k;
                m_z = (m_w == 0); m_n = (m_w >= 128);
            end else if (hi == 8'h0E) begin
                m_w = k;
            end else if (hi == 8'h0D) begin
                m_prod = m_w * k;
            end else if (hi == 8'h0C) begin
                m_w = k; m_ret = 1; m_flush = 1;
            end else if (hi == 8'h01 && k < 16) begin
                m_bank = k;
            end else if (hi == 8'hEE && k < 48) begin
                m_pend = 1; m_sel = k / 16; m_phi = k % 16;
            end else begin
                m_ill = 1;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step(instr_valid, instr);
        m_tag = tag;
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        logic [35:0] eptr;
        logic [4:0]  est;
        eptr = {m_ptr[2][11:0], m_ptr[1][11:0], m_ptr[0][11:0]};
        est  = {m_n, m_ov, m_z, m_dc, m_c};
        if (!done) begin
            checks++;
            if (wreg_o !== m_w[7:0] || status_o !== est || bank_o !== m_bank[3:0]
                || prod_o !== m_prod[15:0] || ptr_o !== eptr || ret_o !== m_ret
                || illegal_o !== m_ill || ready_o !== !m_flush) begin
                errors++;
                $display("FAIL %s model: actual w=%h st=%b bank=%h prod=%h ptr=%h ret=%b ill=%b rdy=%b expected w=%h st=%b bank=%h prod=%h ptr=%h ret=%b ill=%b rdy=%b",
                         m_tag, wreg_o, status_o, bank_o, prod_o, ptr_o, ret_o, illegal_o, ready_o,
                         m_w[7:0], est, m_bank[3:0], m_prod[15:0], eptr, m_ret, m_ill, !m_flush);
            end
        end
    end

    task automatic check_val(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] wd, input string t);
        @(negedge clk);
        tag = t; instr = wd; instr_valid = 1'b1;
    endtask

    task automatic settle();
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        check_val("R1", {wreg_o, status_o, bank_o, prod_o}, '0);
        check_val("R1", {ptr_o, ret_o, illegal_o, ready_o}, 39'h1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // R2 signed overflow into bit 7
        send(16'h0E7F, "R5"); send(16'h0F01, "R2"); settle();
        check_val("R2", {wreg_o, status_o}, {8'h80, 5'b11010});
        // R2 wrap through zero
        send(16'h0EFF, "R5"); send(16'h0F01, "R2"); settle();
        check_val("R2", {wreg_o, status_o}, {8'h00, 5'b00111});
        // R3 borrow on byte and nibble
        send(16'h0E07, "R5"); send(16'h0805, "R3"); settle();
        check_val("R3", {wreg_o, status_o}, {8'hFE, 5'b10000});
        // R3 equal operands: zero, no borrow
        send(16'h0E40, "R5"); send(16'h0840, "R3"); settle();
        check_val("R3", {wreg_o, status_o}, {8'h00, 5'b00111});
        // R3 signed overflow: 0x80 - 0x01
        send(16'h0E01, "R5"); send(16'h0880, "R3"); settle();
        check_val("R3", {wreg_o, status_o}, {8'h7F, 5'b01001});
        // R4 logical ops keep C/DC/OV
        send(16'h0BF0, "R4"); settle();
        check_val("R4", {wreg_o, status_o}, {8'h70, 5'b01001});
        send(16'h0A70, "R4"); settle();
        check_val("R4", {wreg_o, status_o}, {8'h00, 5'b01101});
        send(16'h0981, "R4"); settle();
        check_val("R4", {wreg_o, status_o}, {8'h81, 5'b11001});
        // R6 multiply
        send(16'h0EC8, "R5"); send(16'h0DFA, "R6"); settle();
        check_val("R6", {prod_o, wreg_o}, {16'hC350, 8'hC8});
        // R7 return, then a word in the flush cycle is ignored
        send(16'h0C5A, "R7"); send(16'h0E33, "R7"); settle();
        check_val("R7", {ret_o, ready_o, wreg_o}, {1'b0, 1'b1, 8'h5A});
        send(16'h0C11, "R7"); @(negedge clk);
        check_val("R7", {ret_o, ready_o, wreg_o}, {1'b1, 1'b0, 8'h11});
        instr_valid = 1'b0;
        // R8 bank load, R11 bad bank form
        send(16'h0109, "R8"); send(16'h01F5, "R11"); settle();
        check_val("R8", {bank_o, illegal_o}, {4'h9, 1'b1});
        // R9 pointer loads
        send(16'hEE0A, "R9"); send(16'hF0BC, "R9");
        send(16'hEE15, "R9"); send(16'hF066, "R9");
        send(16'hEE2F, "R9"); send(16'hF001, "R9"); settle();
        check_val("R9", ptr_o, {12'hF01, 12'h566, 12'hABC});
        // R9 cancelled by an intervening word, R10 lone second word
        send(16'hEE03, "R9"); send(16'h0E22, "R9"); send(16'hF044, "R10"); settle();
        check_val("R10", {ptr_o[11:0], wreg_o, illegal_o}, {12'hABC, 8'h22, 1'b0});
        // R9 idle gap between the two words still completes
        send(16'hEE11, "R9"); settle(); settle(); send(16'hF077, "R9"); settle();
        check_val("R9", ptr_o[23:12], 12'h177);
        // R11 illegal select and undefined words
        send(16'hEE31, "R11"); settle();
        check_val("R11", illegal_o, 1'b1);
        send(16'hEE0C, "R11"); send(16'h0000, "R11"); send(16'hF0FF, "R11"); settle();
        check_val("R11", {ptr_o[11:0], illegal_o}, {12'hABC, 1'b0});
        send(16'h0700, "R11"); send(16'h1234, "R11"); send(16'h0E45, "R11"); settle();
        check_val("R11", wreg_o, 8'h45);

        // mixed traffic, compared against the model every cycle
        lf = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            logic [15:0] wd;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[3:0])
                4'h0: wd = 16'hEE00 | {10'h0, lf[9:8], lf[7:4]};
                4'h1: wd = {8'hF0, lf[15:8]};
                4'h2: wd = {12'h010, lf[11:8]};
                4'h3: wd = lf;
                default: wd = {4'h0, 1'b1, lf[6:4], lf[15:8]};
            endcase
            if (lf[9:8] == 2'b11 && lf[3:0] == 4'h0) wd = 16'hEE31;
            @(negedge clk);
            tag = "R2 R3 R4 R9";
            instr = wd; instr_valid = lf[12] | lf[11];
        end
        settle(); settle();
        finish_run();
    end

endmodule